// File: doc/BRIEF.md
# UART Register Block with Interrupt Control

This block is the bus-facing half of a simple byte-oriented UART. It sits on an APB slave port and holds one transmit byte and one receive byte. It also holds the control, status, interrupt-status and baud-divisor registers, and a bank of read-only identification words. It produces four interrupt lines and a combined interrupt line. The bit-level serializer, the deserializer and the baud tick generator sit outside the block. They connect to it through two byte-wide handshakes and a divisor output.

Software writes a byte to the data register. That byte is offered to the serializer while the transmitter is enabled. The serializer returns a one-cycle completion pulse, and the pulse frees the holding buffer. Received bytes are accepted whenever the receiver is enabled. A byte that arrives while the buffer is still full replaces the old byte and raises a receive overrun. A write to a full transmit buffer likewise replaces the byte and raises a transmit overrun. The two overrun interrupt bits are not latched: each one is a live AND of its overrun flag and its enable. The transmit and receive interrupt bits are latched, and software clears them by writing 1.

Top module: `apbuart_ctrl`

## Requirements
- R1: Synchronous reset clears control, status, interrupt status, baud divisor and both byte buffers to zero. Every interrupt output, `tx_valid`, `rx_ready` and `baud_ok` is low after reset.
- R2: Offsets 0xFD0 to 0xFFC (word aligned) read the fixed bytes 04,00,00,00,21,B8,1B,00,0D,F0,05,B1 in rising address order. Any other unmapped offset reads zero. Writes to the ID words or to unmapped offsets change no register.
- R3: The control register (offset 0x08) keeps bits 6:0 of a write. The divisor register (offset 0x10) keeps bits 19:0 of a write. `baud_ok` is high only while the divisor is 16 or more.
- R4: A write to the data register (offset 0x00) while status bit 0 (transmit full) is clear stores the byte and sets bit 0. `tx_valid` is high only while bit 0 is set and control bit 0 (transmit enable) is set.
- R5: A write to the data register while status bit 0 is set replaces the byte on `tx_data` and sets status bit 2 (transmit overrun).
- R6: A `tx_done` pulse while `tx_valid` is high clears status bit 0. If control bit 2 is set, the same pulse also latches interrupt-status bit 0 and `irq_tx`.
- R7: `rx_ready` equals control bit 1 (receive enable). A byte offered while it is low is discarded, and status bit 1 is unchanged.
- R8: An accepted byte sets status bit 1 (receive full) and latches interrupt-status bit 1 and `irq_rx` if control bit 3 is set. A byte accepted while bit 1 is already set replaces the stored byte and sets status bit 3 (receive overrun).
- R9: A read of the data register returns the received byte and clears status bit 1. If a byte is accepted in the same cycle, the new byte is kept, bit 1 stays set and no overrun is raised.
- R10: Status bits 0 and 1 ignore writes. Writing 1 to status bit 2 or bit 3 clears that overrun flag.
- R11: Interrupt-status bits 2 and 3 (offset 0x0C), and `irq_txo` and `irq_rxo`, always equal status bit 2 AND control bit 4, and status bit 3 AND control bit 5. Writing 1 to interrupt-status bit 2 or bit 3 clears the matching overrun flag.
- R12: Writing 1 to interrupt-status bit 0 or bit 1 clears it. `irq_any` is the OR of the four individual interrupt lines.
- R13: Every APB transfer completes in its first access cycle: `pready` is high and `pslverr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| tx_data | output | 8 | Byte offered to the serializer |
| tx_valid | output | 1 | Transmit byte pending and transmitter enabled |
| tx_done | input | 1 | Serializer finished the offered byte (one-cycle pulse) |
| rx_data | input | 8 | Byte from the deserializer |
| rx_valid | input | 1 | Deserializer offers a byte |
| rx_ready | output | 1 | Block accepts received bytes |
| baud_div | output | 20 | Programmed baud divisor |
| baud_ok | output | 1 | Divisor is legal, so bit timing may run |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_txo | output | 1 | Transmit overrun interrupt |
| irq_rxo | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of the four interrupts |

## Verification
A stuck or wrongly set full flag shows at the ports in the cycle after the event that should have changed it. It appears either on `tx_valid` or in the status word, so the bench reads status right after each data write, completion pulse and received byte. An overrun flag or enable that is wrong appears at once on `irq_txo` or `irq_rxo`, because those lines are combinational in the flags. A latched interrupt bit that fails to clear stays visible on `irq_any` until the next write-1 clear. A read racing an arriving byte is checked by the byte and the status seen on the next read.

// File: rtl/apbuart_pkg.sv
package apbuart_pkg;
  localparam logic [11:0] OFS_DATA  = 12'h000;
  localparam logic [11:0] OFS_STAT  = 12'h004;
  localparam logic [11:0] OFS_CTRL  = 12'h008;
  localparam logic [11:0] OFS_INTS  = 12'h00C;
  localparam logic [11:0] OFS_BAUD  = 12'h010;
  localparam logic [11:0] OFS_ID_LO = 12'hFD0;
  localparam logic [11:0] OFS_ID_HI = 12'hFFC;

  // control bit positions
  localparam int CB_TXEN  = 0;
  localparam int CB_RXEN  = 1;
  localparam int CB_TXIE  = 2;
  localparam int CB_RXIE  = 3;
  localparam int CB_TXOIE = 4;
  localparam int CB_RXOIE = 5;

  // identification bytes, indexed by (offset - OFS_ID_LO) / 4
  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h21;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h1B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/apbuart_tx.sv
module apbuart_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  input  logic              ovr_clr,
  input  logic              en,
  input  logic              done,
  output logic [BYTE_W-1:0] dout,
  output logic              valid,
  output logic              full,
  output logic              ovr,
  output logic              fin
);
  logic [BYTE_W-1:0] hold_q;

  assign valid = full & en;
  assign fin   = valid & done;
  assign dout  = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      full   <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (load) hold_q <= din;
      full <= load | (full & ~fin);
      if (load & full & ~fin) ovr <= 1'b1;
      else if (ovr_clr)       ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/apbuart_rx.sv
module apbuart_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              take,
  input  logic              ovr_clr,
  output logic              ready,
  output logic [BYTE_W-1:0] dout,
  output logic              full,
  output logic              ovr,
  output logic              got
);
  logic [BYTE_W-1:0] hold_q;

  assign ready = en;
  assign got   = in_valid & en;
  assign dout  = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      full   <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (got) hold_q <= in_data;
      full <= got | (full & ~take);
      if (got & full & ~take) ovr <= 1'b1;
      else if (ovr_clr)       ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/apbuart_irq.sv
module apbuart_irq #(
  parameter int NLAT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLAT-1:0] set,
  input  logic [NLAT-1:0] clr,
  input  logic [NLAT-1:0] ovr,
  input  logic [NLAT-1:0] ovr_en,
  output logic [2*NLAT-1:0] stat,
  output logic            irq_tx,
  output logic            irq_rx,
  output logic            irq_txo,
  output logic            irq_rxo,
  output logic            irq_any
);
  logic [NLAT-1:0] lat_q;

  for (genvar i = 0; i < NLAT; i++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst)         lat_q[i] <= 1'b0;
      else if (set[i]) lat_q[i] <= 1'b1;
      else if (clr[i]) lat_q[i] <= 1'b0;
    end
  end

  assign stat    = {ovr & ovr_en, lat_q};
  assign irq_tx  = stat[0];
  assign irq_rx  = stat[1];
  assign irq_txo = stat[2];
  assign irq_rxo = stat[3];
  assign irq_any = |stat;
endmodule

// File: rtl/apbuart_ctrl.sv
module apbuart_ctrl #(
  parameter int ADDR_W  = 12,
  parameter int PDATA_W = 32,
  parameter int BYTE_W  = 8,
  parameter int CTRL_W  = 7,
  parameter int DIV_W   = 20,
  parameter int DIV_MIN = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [PDATA_W-1:0] pwdata,
  output logic [PDATA_W-1:0] prdata,
  output logic               pready,
  output logic               pslverr,
  output logic [BYTE_W-1:0]  tx_data,
  output logic               tx_valid,
  input  logic               tx_done,
  input  logic [BYTE_W-1:0]  rx_data,
  input  logic               rx_valid,
  output logic               rx_ready,
  output logic [DIV_W-1:0]   baud_div,
  output logic               baud_ok,
  output logic               irq_tx,
  output logic               irq_rx,
  output logic               irq_txo,
  output logic               irq_rxo,
  output logic               irq_any
);
  import apbuart_pkg::*;

  localparam int NSTAT = 4;

  logic acc, wr, rd;
  logic hit_data, hit_stat, hit_ctrl, hit_ints, hit_baud, hit_id;
  logic [ADDR_W-1:0] id_ofs;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic tx_full, tx_ovr, tx_fin, rx_full, rx_ovr, rx_got;
  logic [BYTE_W-1:0] rx_byte;
  logic [NSTAT-1:0]  status, int_stat;
  logic tx_ovr_clr, rx_ovr_clr;

  assign acc = psel & penable;
  assign wr  = acc & pwrite;
  assign rd  = acc & ~pwrite;

  assign hit_data = paddr == ADDR_W'(OFS_DATA);
  assign hit_stat = paddr == ADDR_W'(OFS_STAT);
  assign hit_ctrl = paddr == ADDR_W'(OFS_CTRL);
  assign hit_ints = paddr == ADDR_W'(OFS_INTS);
  assign hit_baud = paddr == ADDR_W'(OFS_BAUD);
  assign hit_id   = (paddr >= ADDR_W'(OFS_ID_LO)) && (paddr <= ADDR_W'(OFS_ID_HI))
                    && (paddr[1:0] == 2'b00);
  assign id_ofs   = paddr - ADDR_W'(OFS_ID_LO);

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr && hit_ctrl) ctrl_q <= pwdata[CTRL_W-1:0];
      if (wr && hit_baud) div_q  <= pwdata[DIV_W-1:0];
    end
  end

  assign tx_ovr_clr = wr & (hit_stat | hit_ints) & pwdata[2];
  assign rx_ovr_clr = wr & (hit_stat | hit_ints) & pwdata[3];

  apbuart_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst),
    .load(wr & hit_data), .din(pwdata[BYTE_W-1:0]),
    .ovr_clr(tx_ovr_clr), .en(ctrl_q[CB_TXEN]), .done(tx_done),
    .dout(tx_data), .valid(tx_valid), .full(tx_full), .ovr(tx_ovr), .fin(tx_fin)
  );

  apbuart_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst),
    .en(ctrl_q[CB_RXEN]), .in_valid(rx_valid), .in_data(rx_data),
    .take(rd & hit_data), .ovr_clr(rx_ovr_clr),
    .ready(rx_ready), .dout(rx_byte), .full(rx_full), .ovr(rx_ovr), .got(rx_got)
  );

  apbuart_irq #(.NLAT(2)) u_irq (
    .clk(clk), .rst(rst),
    .set({rx_got & ctrl_q[CB_RXIE], tx_fin & ctrl_q[CB_TXIE]}),
    .clr({wr & hit_ints & pwdata[1], wr & hit_ints & pwdata[0]}),
    .ovr({rx_ovr, tx_ovr}),
    .ovr_en({ctrl_q[CB_RXOIE], ctrl_q[CB_TXOIE]}),
    .stat(int_stat),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txo(irq_txo), .irq_rxo(irq_rxo),
    .irq_any(irq_any)
  );

  assign status   = {rx_ovr, tx_ovr, rx_full, tx_full};
  assign baud_div = div_q;
  assign baud_ok  = div_q >= DIV_W'(DIV_MIN);

  always_comb begin
    prdata = '0;
    if (hit_data)      prdata = PDATA_W'(rx_byte);
    else if (hit_stat) prdata = PDATA_W'(status);
    else if (hit_ctrl) prdata = PDATA_W'(ctrl_q);
    else if (hit_ints) prdata = PDATA_W'(int_stat);
    else if (hit_baud) prdata = PDATA_W'(div_q);
    else if (hit_id)   prdata = PDATA_W'(id_byte(id_ofs[5:2]));
  end
endmodule

// File: rtl/apbuart_ctrl_chk.sv
module apbuart_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int CW     = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              tx_valid,
  input logic              tx_done,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq_tx,
  input logic              irq_rx,
  input logic              irq_txo,
  input logic              irq_rxo,
  input logic              irq_any,
  input logic              tx_full,
  input logic              tx_ovr,
  input logic              rx_full,
  input logic [CW-1:0]     ctrl_q
);
  logic data_wr, data_rd, rx_acc;
  assign data_wr = psel && penable && pwrite && (paddr == '0);
  assign data_rd = psel && penable && !pwrite && (paddr == '0);
  assign rx_acc  = rx_valid && rx_ready;

  a_r5_write_full_overruns: assert property (@(posedge clk) disable iff (rst)
    tx_full && data_wr && !(tx_valid && tx_done) |=> tx_ovr);

  a_r6_done_frees_buffer: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_done && !data_wr |=> !tx_full);

  a_r7_discard_when_off: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_ready && !rx_full |=> !rx_full);

  a_r8_accept_fills: assert property (@(posedge clk) disable iff (rst)
    rx_acc |=> rx_full);

  a_r9_read_empties: assert property (@(posedge clk) disable iff (rst)
    data_rd && !rx_acc |=> !rx_full);

  a_r11_txo_live: assert property (@(posedge clk) disable iff (rst)
    irq_txo |-> (ctrl_q[4] && tx_ovr));

  a_r12_any_is_or: assert property (@(posedge clk) disable iff (rst)
    irq_any == (irq_tx || irq_rx || irq_txo || irq_rxo));
endmodule

bind apbuart_ctrl apbuart_ctrl_chk #(.ADDR_W(ADDR_W), .CW(CTRL_W)) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .tx_valid(tx_valid), .tx_done(tx_done),
  .rx_valid(rx_valid), .rx_ready(rx_ready),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txo(irq_txo), .irq_rxo(irq_rxo),
  .irq_any(irq_any), .tx_full(tx_full), .tx_ovr(tx_ovr), .rx_full(rx_full),
  .ctrl_q(ctrl_q)
);

// File: tb/sim_apbuart_ctrl.sv
module sim_apbuart_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_done = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [19:0] baud_div;
  logic        baud_ok;
  logic        irq_tx, irq_rx, irq_txo, irq_rxo, irq_any;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  apbuart_ctrl u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .tx_data(tx_data), .tx_valid(tx_valid), .tx_done(tx_done),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .baud_div(baud_div), .baud_ok(baud_ok), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_txo(irq_txo), .irq_rxo(irq_rxo), .irq_any(irq_any)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] e;
    logic        k;   // 0: identification / unmapped, 1: control and divisor
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VT [NV] = '{
    '{1'b1, 12'h008, 32'hFFFFFFFF, 32'h0,        1'b1},
    '{1'b0, 12'h008, 32'h0,        32'h0000007F, 1'b1},
    '{1'b1, 12'h008, 32'h0,        32'h0,        1'b1},
    '{1'b0, 12'h008, 32'h0,        32'h0,        1'b1},
    '{1'b1, 12'h010, 32'hFFFFFFFF, 32'h0,        1'b1},
    '{1'b0, 12'h010, 32'h0,        32'h000FFFFF, 1'b1},
    '{1'b1, 12'h010, 32'h00000010, 32'h0,        1'b1},
    '{1'b0, 12'h010, 32'h0,        32'h00000010, 1'b1},
    '{1'b0, 12'hFD0, 32'h0,        32'h04,       1'b0},
    '{1'b0, 12'hFD4, 32'h0,        32'h00,       1'b0},
    '{1'b0, 12'hFD8, 32'h0,        32'h00,       1'b0},
    '{1'b0, 12'hFDC, 32'h0,        32'h00,       1'b0},
    '{1'b0, 12'hFE0, 32'h0,        32'h21,       1'b0},
    '{1'b0, 12'hFE4, 32'h0,        32'hB8,       1'b0},
    '{1'b0, 12'hFE8, 32'h0,        32'h1B,       1'b0},
    '{1'b0, 12'hFEC, 32'h0,        32'h00,       1'b0},
    '{1'b0, 12'hFF0, 32'h0,        32'h0D,       1'b0},
    '{1'b0, 12'hFF4, 32'h0,        32'hF0,       1'b0},
    '{1'b0, 12'hFF8, 32'h0,        32'h05,       1'b0},
    '{1'b0, 12'hFFC, 32'h0,        32'hB1,       1'b0},
    '{1'b1, 12'hFE0, 32'h000000FF, 32'h0,        1'b0},
    '{1'b0, 12'hFE0, 32'h0,        32'h21,       1'b0},
    '{1'b1, 12'h020, 32'h00001234, 32'h0,        1'b0},
    '{1'b0, 12'h020, 32'h0,        32'h0,        1'b0},
    '{1'b0, 12'h014, 32'h0,        32'h0,        1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // data read whose access cycle coincides with an arriving byte
  task automatic apb_rd_race(input logic [7:0] b, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = 12'h000; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1; rx_valid = 1'b1; rx_data = b;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_finish();
    @(negedge clk);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R13 reset state
    apb_rd(12'h004, r); chk("R1 status", r, 32'h0);
    apb_rd(12'h008, r); chk("R1 ctrl", r, 32'h0);
    apb_rd(12'h00C, r); chk("R1 intstat", r, 32'h0);
    apb_rd(12'h010, r); chk("R1 divisor", r, 32'h0);
    chk("R1 outputs", {28'h0, irq_any, tx_valid, rx_ready, baud_ok}, 32'h0);
    chk("R13 pready/pslverr", {30'h0, pready, pslverr}, 32'h2);

    // R2 / R3 table
    for (int i = 0; i < NV; i++) begin
      if (VT[i].wr) apb_wr(VT[i].a, VT[i].d);
      else begin
        apb_rd(VT[i].a, r);
        if (VT[i].k) chk("R3 register width", r, VT[i].e);
        else         chk("R2 id/unmapped", r, VT[i].e);
      end
    end
    chk("R3 baud_ok at 16", {31'h0, baud_ok}, 32'h1);
    apb_wr(12'h010, 32'd15);
    chk("R3 baud_ok at 15", {31'h0, baud_ok}, 32'h0);

    // transmit path
    apb_wr(12'h000, 32'h5A);
    apb_rd(12'h004, r); chk("R4 full set", r, 32'h1);
    chk("R4 tx_valid gated by enable", {31'h0, tx_valid}, 32'h0);
    apb_wr(12'h008, 32'h15);
    chk("R4 tx_valid with enable", {23'h0, tx_valid, tx_data}, {23'h0, 1'b1, 8'h5A});
    apb_wr(12'h000, 32'hA5);
    apb_rd(12'h004, r); chk("R5 overrun set", r, 32'h5);
    chk("R5 byte replaced", {24'h0, tx_data}, 32'hA5);
    chk("R11 irq_txo live", {31'h0, irq_txo}, 32'h1);
    apb_rd(12'h00C, r); chk("R11 intstat overrun bit", r, 32'h4);
    tx_finish();
    apb_rd(12'h004, r); chk("R6 full cleared", r, 32'h4);
    chk("R6 irq_tx latched, tx_valid low", {30'h0, irq_tx, tx_valid}, 32'h2);
    apb_rd(12'h00C, r); chk("R6 intstat", r, 32'h5);
    apb_wr(12'h004, 32'h3);
    apb_rd(12'h004, r); chk("R10 read-only bits", r, 32'h4);
    apb_wr(12'h00C, 32'h4);
    apb_rd(12'h004, r); chk("R11 intstat clear hits status", r, 32'h0);
    chk("R11 irq_txo cleared", {31'h0, irq_txo}, 32'h0);
    apb_rd(12'h00C, r); chk("R11 intstat after clear", r, 32'h1);
    apb_wr(12'h00C, 32'h1);
    apb_rd(12'h00C, r); chk("R12 tx bit cleared", r, 32'h0);
    chk("R12 irq_any low", {31'h0, irq_any}, 32'h0);
    apb_wr(12'h000, 32'h01);
    apb_wr(12'h000, 32'h02);
    apb_wr(12'h008, 32'h05);
    chk("R11 enable off masks", {31'h0, irq_txo}, 32'h0);
    apb_rd(12'h00C, r); chk("R11 intstat masked", r, 32'h0);
    apb_wr(12'h008, 32'h15);
    chk("R11 enable on shows", {31'h0, irq_txo}, 32'h1);
    apb_wr(12'h004, 32'h4);
    chk("R10 w1c overrun", {31'h0, irq_txo}, 32'h0);
    tx_finish();
    apb_wr(12'h00C, 32'h1);
    apb_wr(12'h008, 32'h0);

    // receive path
    chk("R7 rx_ready off", {31'h0, rx_ready}, 32'h0);
    rx_send(8'h11);
    apb_rd(12'h004, r); chk("R7 byte discarded", r, 32'h0);
    apb_wr(12'h008, 32'h2A);
    chk("R7 rx_ready on", {31'h0, rx_ready}, 32'h1);
    rx_send(8'h22);
    apb_rd(12'h004, r); chk("R8 full set", r, 32'h2);
    apb_rd(12'h00C, r); chk("R8 rx int latched", r, 32'h2);
    chk("R8 irq_rx", {31'h0, irq_rx}, 32'h1);
    rx_send(8'h33);
    apb_rd(12'h004, r); chk("R8 overrun set", r, 32'hA);
    chk("R8 irq_rxo", {31'h0, irq_rxo}, 32'h1);
    apb_rd(12'h000, r); chk("R8 byte replaced", r, 32'h33);
    apb_rd(12'h004, r); chk("R9 read empties", r, 32'h8);
    apb_wr(12'h004, 32'h8);
    apb_rd(12'h004, r); chk("R10 rx overrun w1c", r, 32'h0);
    chk("R10 irq_rxo low", {31'h0, irq_rxo}, 32'h0);
    apb_wr(12'h00C, 32'h2);
    chk("R12 rx bit cleared", {30'h0, irq_rx, irq_any}, 32'h0);
    rx_send(8'h44);
    apb_rd_race(8'h55, r); chk("R9 race read value", r, 32'h44);
    apb_rd(12'h004, r); chk("R9 incoming wins, no overrun", r, 32'h2);
    apb_rd(12'h000, r); chk("R9 new byte kept", r, 32'h55);
    apb_rd(12'h004, r); chk("R9 empty after read", r, 32'h0);

    // R1 reset in mid-run
    rx_send(8'h66);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    apb_rd(12'h004, r); chk("R1 status after reset", r, 32'h0);
    apb_rd(12'h000, r); chk("R1 buffer after reset", r, 32'h0);
    apb_rd(12'h008, r); chk("R1 ctrl after reset", r, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule